// File: doc/BRIEF.md
# Lockable Translation Lookaside Buffer

This block is a small, fully associative translation cache for a device-side memory management unit. It holds either 8 or 32 entries, chosen by a parameter at elaboration. Each entry pairs a tag word with a data word. The tag word carries the virtual page number, a two-bit page-size code, a pin flag and a valid bit. The data word carries the physical page number plus attribute bits that the cache stores but does not interpret. The four page sizes (4 KB, 64 KB, 1 MB and 16 MB) share one tag array.

Software controls the cache through strobes and a lock register. The lock register holds a base and a victim pointer. A load writes the slot the victim pointer selects and then moves the pointer on. The pointer cycles through the slots at and above the base, so slots below the base stay pinned. The same victim pointer selects which entry the read-back outputs show. There is a strobe that invalidates every entry covering a given address, and a strobe that invalidates everything.

A separate lookup port translates a 32-bit virtual address in the same cycle. It returns a hit flag and the physical address.

Top module: `xlat_tlb`

## Requirements
- R1: After a synchronous reset, every entry is invalid, the lock register reads zero, the read-back outputs are zero, and every lookup misses.
- R2: The lock register holds the base in bits 14:10 and the victim pointer in bits 8:4. A lock write sets both fields, and the register reads back with every other bit zero.
- R3: An accepted load writes the tag word into the slot the victim pointer selects, with bit 2 (valid) forced to 1, and writes the data word into the same slot.
- R4: After an accepted load, the victim pointer advances by one. When the advanced value equals the entry count, the pointer returns to the lock base rather than to zero.
- R5: A load is rejected, leaving every entry and the lock register unchanged, when the base is at or above the entry count or the victim pointer is at or above the entry count.
- R6: The read-back outputs show the tag word and data word of the entry the victim pointer selects.
- R7: Tag bits 1:0 give the page size: 0 is 4 KB, 1 is 64 KB, 2 is 1 MB and 3 is 16 MB. A valid entry covers an address when the address lies in the page-aligned range that starts at the tag's virtual base (tag bits 31:12 with the offset bits cleared) and spans one page.
- R8: On a hit, the physical address is formed from two parts. The bits above the page offset come from the data word's page number (data bits 31:12, offset bits cleared). The offset bits come from the virtual address. Data bits 11:0 never appear in the result.
- R9: When several valid entries cover the lookup address, the entry with the lowest index supplies the translation.
- R10: The flush-entry strobe clears the valid bit of every entry that covers the supplied address. The other fields stay unchanged, and entries that do not cover the address are untouched.
- R11: The flush-all strobe clears the valid bit of every entry and sets both the base and the victim pointer to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_we | input | 1 | Lock register write strobe |
| lock_wdata | input | 32 | Lock register write value (base 14:10, victim 8:4) |
| lock_rdata | output | 32 | Lock register contents |
| ld_stb | input | 1 | Load strobe, writes the victim slot |
| ld_tag | input | 32 | Tag word to load |
| ld_data | input | 32 | Data word to load |
| rd_tag | output | 32 | Tag word of the entry the victim pointer selects |
| rd_data | output | 32 | Data word of the entry the victim pointer selects |
| fl_ent_stb | input | 1 | Flush-by-address strobe |
| fl_addr | input | 32 | Address for flush-by-address |
| fl_all_stb | input | 1 | Flush-all strobe |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Lookup physical address, valid when lk_hit is high |

## Verification
The assertions assume that at most one of the lock write, load, flush-entry and flush-all strobes is high in any cycle. The RTL does define a priority among them: flush-all beats a lock write, and a lock write beats a load. However, the pointer-wrap and entry-clear properties are written for isolated strobes. The stimulus raises each strobe for a single cycle and returns it low before the next operation. The wrap property is only claimed when the victim pointer starts at or above the base. The bench therefore always sets the victim at or above the base, except when it deliberately forces a full lock base to provoke a rejected load.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

    localparam int VA_W       = 32;
    localparam int PN_W       = 20;
    localparam int PTR_W      = 5;
    localparam int LK_BASE_LO = 10;
    localparam int LK_VICT_LO = 4;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pgsz_e;

    typedef struct packed {
        logic [PN_W-1:0] vpn;
        logic [7:0]      rsvd;
        logic            pin;
        logic            vld;
        pgsz_e           sz;
    } tag_t;

    typedef struct packed {
        logic [PN_W-1:0] ppn;
        logic [11:0]     attr;
    } dat_t;

    function automatic logic [VA_W-1:0] off_mask(pgsz_e s);
        case (s)
            PG_4K:   off_mask = 32'h0000_0FFF;
            PG_64K:  off_mask = 32'h0000_FFFF;
            PG_1M:   off_mask = 32'h000F_FFFF;
            default: off_mask = 32'h00FF_FFFF;
        endcase
    endfunction

    function automatic logic covers(tag_t t, logic [VA_W-1:0] va);
        logic [VA_W-1:0] m;
        m = off_mask(t.sz);
        covers = t.vld && ((({t.vpn, 12'h000}) & ~m) == (va & ~m));
    endfunction

endpackage

// File: rtl/xlat_tlb_lock.sv
module xlat_tlb_lock
    import xlat_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_we,
    input  logic [31:0]      lock_wdata,
    input  logic             ld_stb,
    input  logic             fl_all,
    output logic [PTR_W-1:0] base_o,
    output logic [PTR_W-1:0] vict_o,
    output logic             ld_ok_o
);

    localparam logic [PTR_W:0] NENT = (PTR_W+1)'(N_ENTRIES);

    logic [PTR_W-1:0] base_q, vict_q, vict_nxt;
    logic [PTR_W:0]   vict_inc;
    logic             room;

    assign room     = ({1'b0, base_q} < NENT) && ({1'b0, vict_q} < NENT);
    assign ld_ok_o  = ld_stb && !fl_all && !lock_we && room;
    assign vict_inc = {1'b0, vict_q} + 1'b1;
    assign vict_nxt = (vict_inc == NENT) ? base_q : vict_inc[PTR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || fl_all) begin
            base_q <= '0;
            vict_q <= '0;
        end else if (lock_we) begin
            base_q <= lock_wdata[LK_BASE_LO +: PTR_W];
            vict_q <= lock_wdata[LK_VICT_LO +: PTR_W];
        end else if (ld_ok_o) begin
            vict_q <= vict_nxt;
        end
    end

    assign base_o = base_q;
    assign vict_o = vict_q;

    AST_VICT_STAYS_ABOVE_BASE: assert property (@(posedge clk) disable iff (rst)
        (ld_ok_o && (vict_q >= base_q)) |=>
        ((vict_q >= base_q) && ({1'b0, vict_q} < NENT))); // R4

    AST_FULL_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && !lock_we && !fl_all && ({1'b0, base_q} >= NENT)) |=>
        ($stable(vict_q) && $stable(base_q))); // R5

    AST_FLUSH_ALL_CLEARS_LOCK: assert property (@(posedge clk) disable iff (rst)
        fl_all |=> ((base_q == '0) && (vict_q == '0))); // R11

endmodule

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store
    import xlat_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  tag_t             wr_tag,
    input  dat_t             wr_dat,
    input  logic             fl_ent,
    input  logic [VA_W-1:0]  fl_addr,
    input  logic             fl_all,
    output tag_t             tag_q [N_ENTRIES],
    output dat_t             dat_q [N_ENTRIES]
);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
        logic hit_wr;
        logic hit_fl;

        assign hit_wr = wr_en && (wr_idx == PTR_W'(i));
        assign hit_fl = fl_ent && covers(tag_q[i], fl_addr);

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end else if (fl_all) begin
                tag_q[i].vld <= 1'b0;
            end else if (hit_wr) begin
                tag_q[i]     <= wr_tag;
                tag_q[i].vld <= 1'b1;
                dat_q[i]     <= wr_dat;
            end else if (hit_fl) begin
                tag_q[i].vld <= 1'b0;
            end
        end

        AST_LOAD_MARKS_VALID: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !fl_all && (wr_idx == PTR_W'(i))) |=>
            (tag_q[i].vld && (tag_q[i].vpn == $past(wr_tag.vpn)))); // R3

        AST_FLUSH_ENT_DROPS: assert property (@(posedge clk) disable iff (rst)
            (fl_ent && !fl_all && !(wr_en && (wr_idx == PTR_W'(i))) &&
             covers(tag_q[i], fl_addr)) |=>
            (!tag_q[i].vld && $stable(tag_q[i].vpn))); // R10

        AST_FLUSH_ALL_DROPS: assert property (@(posedge clk) disable iff (rst)
            fl_all |=> !tag_q[i].vld); // R11
    end

endmodule

// File: rtl/xlat_tlb_match.sv
module xlat_tlb_match
    import xlat_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 32
) (
    input  tag_t            tags [N_ENTRIES],
    input  dat_t            dats [N_ENTRIES],
    input  logic [VA_W-1:0] va,
    output logic            hit,
    output logic [VA_W-1:0] pa
);

    logic [VA_W-1:0] m;

    always_comb begin
        hit = 1'b0;
        pa  = '0;
        m   = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (covers(tags[i], va)) begin
                hit = 1'b1;
                m   = off_mask(tags[i].sz);
                pa  = ({dats[i].ppn, 12'h000} & ~m) | (va & m);
            end
        end
    end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lock_we,
    input  logic [31:0] lock_wdata,
    output logic [31:0] lock_rdata,
    input  logic        ld_stb,
    input  logic [31:0] ld_tag,
    input  logic [31:0] ld_data,
    output logic [31:0] rd_tag,
    output logic [31:0] rd_data,
    input  logic        fl_ent_stb,
    input  logic [31:0] fl_addr,
    input  logic        fl_all_stb,
    input  logic [31:0] lk_va,
    output logic        lk_hit,
    output logic [31:0] lk_pa
);

    if (!((N_ENTRIES == 8) || (N_ENTRIES == 32))) begin : g_bad_cfg
        $error("xlat_tlb: N_ENTRIES must be 8 or 32");
    end

    logic [PTR_W-1:0] base, vict;
    logic             ld_ok;
    tag_t             tag_q [N_ENTRIES];
    dat_t             dat_q [N_ENTRIES];

    xlat_tlb_lock #(.N_ENTRIES(N_ENTRIES)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .lock_we    (lock_we),
        .lock_wdata (lock_wdata),
        .ld_stb     (ld_stb),
        .fl_all     (fl_all_stb),
        .base_o     (base),
        .vict_o     (vict),
        .ld_ok_o    (ld_ok)
    );

    xlat_tlb_store #(.N_ENTRIES(N_ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ld_ok),
        .wr_idx  (vict),
        .wr_tag  (tag_t'(ld_tag)),
        .wr_dat  (dat_t'(ld_data)),
        .fl_ent  (fl_ent_stb),
        .fl_addr (fl_addr),
        .fl_all  (fl_all_stb),
        .tag_q   (tag_q),
        .dat_q   (dat_q)
    );

    xlat_tlb_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .tags (tag_q),
        .dats (dat_q),
        .va   (lk_va),
        .hit  (lk_hit),
        .pa   (lk_pa)
    );

    always_comb begin
        lock_rdata = '0;
        lock_rdata[LK_BASE_LO +: PTR_W] = base;
        lock_rdata[LK_VICT_LO +: PTR_W] = vict;
    end

    always_comb begin
        rd_tag  = '0;
        rd_data = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (vict == PTR_W'(i)) begin
                rd_tag  = tag_q[i];
                rd_data = dat_q[i];
            end
        end
    end

    AST_RESET_LOCK_ZERO: assert property (@(posedge clk)
        $past(rst) |-> (lock_rdata == 32'h0)); // R1

endmodule

// File: tb/xlat_tlb_tb.sv
`timescale 1ns/100ps
module xlat_tlb_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lock_we = 1'b0;
    logic [31:0] lock_wdata = '0;
    logic [31:0] lock_rdata;
    logic        ld_stb = 1'b0;
    logic [31:0] ld_tag = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] rd_tag, rd_data;
    logic        fl_ent_stb = 1'b0;
    logic [31:0] fl_addr = '0;
    logic        fl_all_stb = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_hit;
    logic [31:0] lk_pa;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    xlat_tlb #(.N_ENTRIES(8)) u_dut (
        .clk(clk), .rst(rst),
        .lock_we(lock_we), .lock_wdata(lock_wdata), .lock_rdata(lock_rdata),
        .ld_stb(ld_stb), .ld_tag(ld_tag), .ld_data(ld_data),
        .rd_tag(rd_tag), .rd_data(rd_data),
        .fl_ent_stb(fl_ent_stb), .fl_addr(fl_addr), .fl_all_stb(fl_all_stb),
        .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa)
    );

    // lookup vectors: {va, expected hit, expected pa}
    localparam logic [64:0] VEC [0:11] = '{
        {32'h0000_1234, 1'b1, 32'h8000_0234},   // R7 R8 4K, attr bits hidden
        {32'h0000_2000, 1'b0, 32'h0},           // R7 one past 4K page
        {32'h0000_0FFF, 1'b0, 32'h0},           // R7 just below 4K page
        {32'h0001_ABCD, 1'b1, 32'h9000_ABCD},   // R7 R8 64K
        {32'h0002_0000, 1'b0, 32'h0},           // R7 end of 64K page
        {32'h0015_6789, 1'b1, 32'hA005_6789},   // R8 1M
        {32'h0010_2345, 1'b1, 32'hA000_2345},   // R9 1M slot beats 4K slot
        {32'h01FF_FFFF, 1'b1, 32'hB0FF_FFFF},   // R7 top of 16M page
        {32'h0100_0000, 1'b1, 32'hB000_0000},   // R7 16M base masked
        {32'h0200_0000, 1'b0, 32'h0},           // R7 end of 16M page
        {32'h00FF_FFFF, 1'b0, 32'h0},           // R7 below 16M page
        {32'h0300_0010, 1'b1, 32'hD000_0010}    // R3 slot loaded at wrap
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic lk(input string req, input logic [31:0] va, input logic h, input logic [31:0] pa);
        lk_va = va;
        #1;
        chk(req, {31'h0, lk_hit}, {31'h0, h});
        if (h) chk(req, lk_pa, pa);
    endtask

    task automatic wr_lock(input logic [4:0] b, input logic [4:0] v);
        lock_wdata = {17'h0, b, 1'b0, v, 4'h0};
        lock_we = 1'b1;
        @(posedge clk); #1;
        lock_we = 1'b0;
    endtask

    task automatic load(input logic [31:0] t, input logic [31:0] d);
        ld_tag = t; ld_data = d; ld_stb = 1'b1;
        @(posedge clk); #1;
        ld_stb = 1'b0;
    endtask

    task automatic flush_at(input logic [31:0] a);
        fl_addr = a; fl_ent_stb = 1'b1;
        @(posedge clk); #1;
        fl_ent_stb = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 lock", lock_rdata, 32'h0);
        chk("R1 rd_tag", rd_tag, 32'h0);
        lk("R1 lookup", 32'h0000_0000, 1'b0, 32'h0);

        // R2 lock register fields
        wr_lock(5'd2, 5'd2);
        chk("R2 lock", lock_rdata, 32'h0000_0820);

        load(32'h0000_1000, 32'h8000_0ABC);   // slot 2, 4K
        load(32'h0001_0001, 32'h9000_0000);   // slot 3, 64K
        load(32'h0010_0002, 32'hA000_0000);   // slot 4, 1M
        load(32'h0123_4003, 32'hB000_0000);   // slot 5, 16M
        load(32'h0010_2000, 32'hC000_0000);   // slot 6, 4K inside slot 4
        chk("R4 advance", lock_rdata, 32'h0000_0870);
        load(32'h0300_0000, 32'hD000_0000);   // slot 7
        chk("R4 wrap to base", lock_rdata, 32'h0000_0820);

        for (int i = 0; i < 12; i++)
            lk("R7/R8/R9 vector", VEC[i][64:33], VEC[i][32], VEC[i][31:0]);

        // R6 read back, R3 valid forced
        wr_lock(5'd2, 5'd3);
        chk("R3 R6 tag", rd_tag, 32'h0001_0005);
        chk("R6 data", rd_data, 32'h9000_0000);
        wr_lock(5'd2, 5'd0);
        chk("R4 pinned slot untouched", rd_tag, 32'h0);

        // R10 flush by address
        flush_at(32'h0001_8000);
        lk("R10 flushed miss", 32'h0001_ABCD, 1'b0, 32'h0);
        lk("R10 other kept", 32'h0000_1234, 1'b1, 32'h8000_0234);
        wr_lock(5'd2, 5'd3);
        chk("R10 tag kept", rd_tag, 32'h0001_0001);
        flush_at(32'h0010_2000);
        lk("R10 both covers cleared", 32'h0010_2345, 1'b0, 32'h0);
        lk("R10 16M kept", 32'h0100_0004, 1'b1, 32'hB000_0004);

        // R5 rejected load
        wr_lock(5'd8, 5'd5);
        load(32'h0F00_0000, 32'hE000_0000);
        chk("R5 lock unchanged", lock_rdata, 32'h0000_2050);
        chk("R5 slot unchanged", rd_tag, 32'h0123_4007);
        lk("R5 no entry", 32'h0F00_0000, 1'b0, 32'h0);

        // R11 flush all
        fl_all_stb = 1'b1;
        @(posedge clk); #1;
        fl_all_stb = 1'b0;
        chk("R11 lock zero", lock_rdata, 32'h0);
        lk("R11 miss", 32'h01FF_FFFF, 1'b0, 32'h0);
        lk("R11 miss 4K", 32'h0000_1234, 1'b0, 32'h0);
        wr_lock(5'd0, 5'd5);
        chk("R11 valid cleared", rd_tag, 32'h0123_4003);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule